// File: doc/BRIEF.md
# Irregular-Sequence JK Counter

The block is a 3-bit synchronous counter built from three JK flip-flop stages that share one clock. Fixed excitation equations feed the stages, so the counter walks a short, non-binary cycle of four states instead of incrementing. A count enable lets the counter advance or hold. A flag marks the state where the cycle starts, so a consumer can frame every four counting steps.

The equations are chosen so that each of the four unused codes falls back into the main cycle within a few enabled clocks. The counter therefore cannot lock up after an upset. A test preset port loads any 3-bit code on the next clock edge. It exists so that the recovery paths can be exercised; in normal use it is tied low.

Top module: `irr_seq_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, the state becomes 001 (written as q[2]q[1]q[0]). This takes priority over `test_force` and `cnt_en`.
- R2: With `cnt_en` at 1 and no reset or preset, the state follows the cycle 001 → 011 → 101 → 110 → 001, one step per rising edge.
- R3: With `cnt_en` at 0 and no reset or preset, the state stays the same across the edge.
- R4: With counting enabled, the unused codes step as follows: 000 → 011, 010 → 101, 100 → 111, 111 → 000.
- R5: `cycle_start` is 1 exactly when the state is 001.
- R6: With `test_force` at 1 and `rst` at 0, the state becomes `test_value` at the next edge, whatever `cnt_en` is.
- R7: On every enabled counting edge, q[1] inverts.
- R8: On an enabled counting edge, q[2] changes only if q[1] was 1 before the edge. It inverts if q[1] was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; 0 holds all stages |
| test_force | input | 1 | Test preset strobe, active high |
| test_value | input | 3 | Code loaded by the test preset |
| q | output | 3 | Counter state, bit 2 is the most significant |
| cycle_start | output | 1 | High while the state is 001 |

## Verification
The hardest condition to reach from the ports is an unused code. Reset and counting only ever visit the four states of the main cycle. The stimulus uses the test preset to place the counter in each of the eight codes, then clocks with enable high and checks every recovery step against a bench transition table. Random runs mix presets, held cycles and rare resets, so the recovery paths are also entered with enable low and followed at irregular points.

// File: rtl/irr_cnt_pkg.sv
package irr_cnt_pkg;

    localparam int CNT_W = 3;

    typedef logic [CNT_W-1:0] cnt_state_t;

    localparam cnt_state_t START_CODE = 3'b001;

    // drive pair for one JK stage
    typedef struct packed {
        logic j;
        logic k;
    } jk_drive_t;

    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_action_t;

    function automatic jk_action_t jk_decode(input jk_drive_t d);
        return jk_action_t'({d.j, d.k});
    endfunction

endpackage

// File: rtl/jk_stage.sv
module jk_stage
    import irr_cnt_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ld,
    input  logic      ld_val,
    input  logic      en,
    input  jk_drive_t drv,
    output logic      q
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RST_VAL;
        end else if (ld) begin
            q_r <= ld_val;
        end else if (en) begin
            unique case (jk_decode(drv))
                JK_HOLD:   q_r <= q_r;
                JK_CLEAR:  q_r <= 1'b0;
                JK_SET:    q_r <= 1'b1;
                JK_TOGGLE: q_r <= ~q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/irr_excite.sv
module irr_excite
    import irr_cnt_pkg::*;
(
    input  cnt_state_t cur,
    output jk_drive_t  drv [CNT_W]
);

    always_comb begin
        // stage 0: J high, K follows the top bit
        drv[0].j = 1'b1;
        drv[0].k = cur[2];
        // stage 1: always toggles
        drv[1].j = 1'b1;
        drv[1].k = 1'b1;
        // stage 2: toggles when the middle bit is set
        drv[2].j = cur[1];
        drv[2].k = cur[1];
    end

endmodule

// File: rtl/irr_seq_counter.sv
module irr_seq_counter
    import irr_cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             test_force,
    input  logic [CNT_W-1:0] test_value,
    output logic [CNT_W-1:0] q,
    output logic             cycle_start
);

    cnt_state_t state;
    jk_drive_t  drv [CNT_W];

    irr_excite u_excite (
        .cur (state),
        .drv (drv)
    );

    for (genvar g = 0; g < CNT_W; g++) begin : g_stage
        jk_stage #(
            .RST_VAL (START_CODE[g])
        ) u_jk (
            .clk    (clk),
            .rst    (rst),
            .ld     (test_force),
            .ld_val (test_value[g]),
            .en     (cnt_en),
            .drv    (drv[g]),
            .q      (state[g])
        );
    end

    assign q           = state;
    assign cycle_start = (state == START_CODE);

endmodule

// File: rtl/irr_seq_counter_chk.sv
module irr_seq_counter_chk
    import irr_cnt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             test_force,
    input logic [CNT_W-1:0] test_value,
    input logic [CNT_W-1:0] q,
    input logic             cycle_start
);

    logic counting;
    assign counting = !rst && !test_force && cnt_en;

    AST_RESET_START: assert property (@(posedge clk) rst |=> (q == 3'b001)); // R1
    AST_MAIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (counting && q == 3'b110) |=> cycle_start); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!test_force && !cnt_en) |=> $stable(q)); // R3
    AST_RECOVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (counting && q == 3'b000) |=> (q == 3'b011)); // R4
    AST_FLAG_AFTER_RST: assert property (@(posedge clk) rst |=> cycle_start); // R5
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        test_force |=> (q == $past(test_value))); // R6
    AST_MID_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        counting |=> (q[1] != $past(q[1]))); // R7
    AST_TOP_GATED: assert property (@(posedge clk) disable iff (rst)
        (counting && !q[1]) |=> $stable(q[2])); // R8

endmodule

bind irr_seq_counter irr_seq_counter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .test_force  (test_force),
    .test_value  (test_value),
    .q           (q),
    .cycle_start (cycle_start)
);

// File: tb/test_irr_seq_counter.sv
module test_irr_seq_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       test_force = 1'b0;
    logic [2:0] test_value = 3'b000;
    logic [2:0] q;
    logic       cycle_start;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [2:0] exp_q = 3'b001;

    always #4 clk = ~clk;

    irr_seq_counter i_irr_seq_counter (
        .clk         (clk),
        .rst         (rst),
        .cnt_en      (cnt_en),
        .test_force  (test_force),
        .test_value  (test_value),
        .q           (q),
        .cycle_start (cycle_start)
    );

    // transition table taken from R2 and R4
    function automatic logic [2:0] count_next(input logic [2:0] s);
        case (s)
            3'b001: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b001;
            3'b000: return 3'b011;
            3'b010: return 3'b101;
            3'b100: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic bit in_main(input logic [2:0] s);
        return (s == 3'b001) || (s == 3'b011) || (s == 3'b101) || (s == 3'b110);
    endfunction

    task automatic check_state(input string tag);
        total++;
        if (q !== exp_q) begin
            bad++;
            $display("FAIL %s state: actual=%b expected=%b", tag, q, exp_q);
        end
        total++;
        if (cycle_start !== (exp_q == 3'b001)) begin
            bad++;
            $display("FAIL R5 flag: actual=%b expected=%b", cycle_start, exp_q == 3'b001);
        end
    endtask

    task automatic step(input bit r, input bit f, input logic [2:0] v, input bit e);
        string tag;
        @(negedge clk);
        rst = r; test_force = f; test_value = v; cnt_en = e;
        if (r) begin
            tag = "R1"; exp_q = 3'b001;
        end else if (f) begin
            tag = "R6"; exp_q = v;
        end else if (!e) begin
            tag = "R3";
        end else begin
            tag = in_main(exp_q) ? "R2/R7/R8" : "R4/R7/R8";
            exp_q = count_next(exp_q);
        end
        @(posedge clk);
        #1;
        check_state(tag);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // reset state, with force and enable also high
        step(1'b1, 1'b1, 3'b110, 1'b1);
        step(1'b1, 1'b0, 3'b000, 1'b0);
        // walk the main cycle twice
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'b000, 1'b1);
        // hold in several states
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b0, 1'b0, 3'b000, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'b000, 1'b0);
        // seed every code, then count and hold from it
        for (int s = 0; s < 8; s++) begin
            step(1'b0, 1'b1, 3'(s), 1'b0);
            step(1'b0, 1'b0, 3'b000, 1'b0);
            for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 3'b000, 1'b1);
        end
        // preset wins over enable
        step(1'b0, 1'b1, 3'b100, 1'b1);
        step(1'b0, 1'b0, 3'b000, 1'b1);
        step(1'b0, 1'b0, 3'b000, 1'b1);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit r, f, e;
            logic [2:0] v;
            r = ($urandom % 40) == 0;
            f = ($urandom % 8) == 0;
            e = ($urandom % 4) != 0;
            v = 3'($urandom);
            step(r, f, v, e);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule